// File: doc/BRIEF.md
# Parallel ADC conversion and read sequencer

This block is a synchronous controller for a 14-bit converter that has a parallel output bus. While `run` is high, it repeats one sample cycle. Each cycle follows these steps:

1. Pulse the active-low convert-start strobe.
2. Wait for the converter's busy flag to rise and then fall.
3. Lower chip-select and read together, long enough for the output data to settle.
4. Latch the bus on the final edge of the read pulse.
5. Hold off the next start until the bus-release and acquisition intervals have passed.

The latched word appears on `smp_data` with a one-cycle `smp_valid` pulse.

Every analog timing limit is a parameter in nanoseconds. The block converts each one to system-clock cycles, rounding up, using `CLK_NS`. The busy flag passes through one input register. For that reason, both busy timeouts carry an extra `MARGIN_CYC` cycles of slack.

If busy never rises, or never falls, within its window, the cycle is abandoned. A saturating error counter then steps up by one. `sleep` drives the converter's standby pin. When sleep is released, a wake-up interval must pass before the next conversion starts.

Top module: `adc_seq`

## Requirements
- R1: Reset puts the block in its rest state on the first clock edge where synchronous active-high `rst` is sampled high. In that state `adc_convst_n`, `adc_cs_n`, `adc_rd_n` and `adc_stby_n` are all 1, `smp_valid` is 0 and `err_count` is 0.
- R2: Every low pulse of `adc_convst_n` lasts at least ceil(`CONVST_MIN_NS`/`CLK_NS`) clock cycles.
- R3: `adc_rd_n` falls only after busy has been seen high and then seen low again. It is never low while `adc_busy` is 1.
- R4: `adc_cs_n` and `adc_rd_n` fall and rise together. The low pulse lasts the larger of the read pulse width and the data access time. The access time is `RD_ACCESS_3V_NS` when `VIO_3V` is 1 and `RD_ACCESS_5V_NS` when it is 0.
- R5: From each rising edge of `adc_rd_n` to the next falling edge of `adc_convst_n`, at least the larger of `ACQ_NS` and `RELINQ_NS` elapses.
- R6: While `sleep` is high and the block is idle, `adc_stby_n` is 0 and no conversion starts. After `adc_stby_n` rises, the next falling edge of `adc_convst_n` comes at least `WAKE_NS` later.
- R7: If busy is not seen high within ceil(`BUSY_RISE_NS`/`CLK_NS`)+`MARGIN_CYC` cycles after convert-start rises, the cycle aborts. `err_count` increases by one, no read strobe is issued, no sample is emitted, and the block returns to idle.
- R8: If busy stays high longer than ceil(`CONV_MAX_NS`/`CLK_NS`)+`MARGIN_CYC` cycles, the cycle aborts with the same effects as R7.
- R9: Each completed conversion yields exactly one `smp_valid` pulse, one cycle long, in the cycle after `adc_rd_n` rises. `smp_data` carries the bus value that was present on that edge.
- R10: `err_count` saturates at all ones. An abort at that value leaves it unchanged.
- R11: With `run` low, a cycle already in progress finishes, and then no further convert-start strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep starting sample cycles while high |
| sleep | input | 1 | Request converter standby (taken when idle) |
| adc_busy | input | 1 | Converter busy flag, high during conversion |
| adc_data | input | DATA_W | Converter parallel data bus |
| adc_convst_n | output | 1 | Convert-start strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_stby_n | output | 1 | Standby control, low puts converter to sleep |
| smp_valid | output | 1 | One-cycle pulse marking a new sample |
| smp_data | output | DATA_W | Most recent captured sample |
| err_count | output | ERR_W | Saturating count of aborted cycles |

## Verification
The bench uses a 5 ns clock with the nanosecond defaults. Those defaults give the following windows:

| Interval | Cycles |
|---|---|
| Convert-start pulse | 7 |
| Busy-rise window | 18 |
| Busy-fall window | 444 |
| Gap after read | 60 |
| Wake-up | 400 |

The bench sets `VIO_3V` to 1, so the read window is 8 cycles. Its converter model presents valid data only 37 ns after the read strobe falls, so sampling even one cycle early latches a wrong word.

`ERR_W` is set to 3. The counter therefore reaches its saturation value of 7 after a handful of aborted cycles, which puts R10 within a short run.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SLEEP, S_WAKE, S_CONV, S_BRISE, S_BFALL, S_READ, S_GAP
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int cyc_ceil(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_seq_capture.sv
`timescale 1ns/1ps
module adc_seq_capture #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] bus,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= cap;
      if (cap) data <= bus;
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/adc_seq_errcnt.sv
`timescale 1ns/1ps
module adc_seq_errcnt #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [ERR_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (inc && !(&count))  count <= count + 1'b1;
  end

  // R10
  err_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (&count) |=> (&count));

  // R7
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> (count == $past(count)));
endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_NS          = 5,
  parameter int DATA_W          = 14,
  parameter int ERR_W           = 8,
  parameter int CONVST_MIN_NS   = 35,
  parameter int BUSY_RISE_NS    = 70,
  parameter int CONV_MAX_NS     = 2200,
  parameter int MARGIN_CYC      = 4,
  parameter int RD_PULSE_NS     = 35,
  parameter int RD_ACCESS_5V_NS = 35,
  parameter int RD_ACCESS_3V_NS = 40,
  parameter bit VIO_3V          = 1'b0,
  parameter int RELINQ_NS       = 30,
  parameter int ACQ_NS          = 300,
  parameter int WAKE_NS         = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sleep,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_convst_n,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              adc_stby_n,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic [ERR_W-1:0]  err_count
);
  localparam int ACC_NS    = VIO_3V ? RD_ACCESS_3V_NS : RD_ACCESS_5V_NS;
  localparam int T1_CYC    = cyc_ceil(CONVST_MIN_NS, CLK_NS);
  localparam int BRISE_CYC = cyc_ceil(BUSY_RISE_NS, CLK_NS) + MARGIN_CYC;
  localparam int BFALL_CYC = cyc_ceil(CONV_MAX_NS, CLK_NS) + MARGIN_CYC;
  localparam int RD_CYC    = imax(cyc_ceil(ACC_NS, CLK_NS), cyc_ceil(RD_PULSE_NS, CLK_NS));
  localparam int GAP_CYC   = imax(cyc_ceil(ACQ_NS, CLK_NS), cyc_ceil(RELINQ_NS, CLK_NS));
  localparam int WAKE_CYC  = cyc_ceil(WAKE_NS, CLK_NS);
  localparam int MAX_CYC   = imax(imax(imax(T1_CYC, BRISE_CYC), imax(BFALL_CYC, RD_CYC)),
                                  imax(GAP_CYC, WAKE_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_t        state, nxt;
  logic              busy_q;
  logic              ld, expired, err_inc, cap;
  logic [CNT_W-1:0]  ld_val;

  always_comb begin
    nxt     = state;
    ld      = 1'b0;
    ld_val  = '0;
    err_inc = 1'b0;
    cap     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (sleep) nxt = S_SLEEP;
        else if (run) begin
          nxt = S_CONV;  ld = 1'b1;  ld_val = CNT_W'(T1_CYC - 1);
        end
      end
      S_SLEEP: if (!sleep) begin
        nxt = S_WAKE;  ld = 1'b1;  ld_val = CNT_W'(WAKE_CYC - 1);
      end
      S_WAKE: if (expired) nxt = S_IDLE;
      S_CONV: if (expired) begin
        nxt = S_BRISE;  ld = 1'b1;  ld_val = CNT_W'(BRISE_CYC - 1);
      end
      S_BRISE: begin
        if (busy_q) begin
          nxt = S_BFALL;  ld = 1'b1;  ld_val = CNT_W'(BFALL_CYC - 1);
        end else if (expired) begin
          nxt = S_IDLE;  err_inc = 1'b1;
        end
      end
      S_BFALL: begin
        if (!busy_q) begin
          nxt = S_READ;  ld = 1'b1;  ld_val = CNT_W'(RD_CYC - 1);
        end else if (expired) begin
          nxt = S_IDLE;  err_inc = 1'b1;
        end
      end
      S_READ: if (expired) begin
        cap = 1'b1;  nxt = S_GAP;  ld = 1'b1;  ld_val = CNT_W'(GAP_CYC - 1);
      end
      S_GAP: if (expired) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      busy_q       <= 1'b0;
      adc_convst_n <= 1'b1;
      adc_cs_n     <= 1'b1;
      adc_rd_n     <= 1'b1;
      adc_stby_n   <= 1'b1;
    end else begin
      state        <= nxt;
      busy_q       <= adc_busy;
      adc_convst_n <= (nxt != S_CONV);
      adc_cs_n     <= (nxt != S_READ);
      adc_rd_n     <= (nxt != S_READ);
      adc_stby_n   <= (nxt != S_SLEEP);
    end
  end

  adc_seq_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .expired(expired)
  );

  adc_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap(cap), .bus(adc_data),
    .valid(smp_valid), .data(smp_data)
  );

  adc_seq_errcnt #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .inc(err_inc), .count(err_count)
  );

  // width of the current convert-start low pulse, for the R2 check
  logic [CNT_W-1:0] lo_run;
  always_ff @(posedge clk) begin
    if (rst || adc_convst_n)          lo_run <= '0;
    else if (lo_run < CNT_W'(T1_CYC)) lo_run <= lo_run + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (adc_convst_n && adc_rd_n && adc_cs_n && adc_stby_n && !smp_valid));

  // R2
  convst_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_convst_n) |-> (lo_run >= CNT_W'(T1_CYC)));

  // R3
  rd_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_rd_n) |-> $past(!busy_q));

  // R9
  valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_rd_n) |-> smp_valid);
endmodule

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;
  localparam int DW = 14;
  localparam int EW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, run = 1'b0, sleep = 1'b0, adc_busy = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic adc_convst_n, adc_cs_n, adc_rd_n, adc_stby_n, smp_valid;
  logic [DW-1:0] smp_data;
  logic [EW-1:0] err_count;

  adc_seq #(.CLK_NS(5), .DATA_W(DW), .ERR_W(EW), .VIO_3V(1'b1)) uut (
    .clk(clk), .rst(rst), .run(run), .sleep(sleep), .adc_busy(adc_busy),
    .adc_data(adc_data), .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n),
    .adc_rd_n(adc_rd_n), .adc_stby_n(adc_stby_n), .smp_valid(smp_valid),
    .smp_data(smp_data), .err_count(err_count)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model: 0 normal, 1 busy never rises, 2 busy stuck high
  int mode = 0;
  int conv_idx = 0, conv_done = 0;
  logic [DW-1:0] word_ready = '0;

  function automatic logic [DW-1:0] gen(input int k);
    if (k == 0) return '0;
    if (k == 1) return '1;
    return DW'(k * 32'h0B3D + 32'h1111);
  endfunction

  always @(posedge adc_convst_n) if (!rst) begin
    if (mode == 0) begin
      #51 adc_busy = 1'b1;
      #2001 word_ready = gen(conv_idx);
      conv_idx++;
      conv_done++;
      adc_busy = 1'b0;
    end else if (mode == 2) begin
      #51 adc_busy = 1'b1;
      wait (mode != 2);
      adc_busy = 1'b0;
    end
  end

  // bus holds a wrong word until 37 ns after the read strobe falls
  always @(negedge adc_rd_n) begin
    adc_data = ~word_ready;
    #37 adc_data = word_ready;
  end

  // timing monitors
  real t_cv_fall = 0.0, t_rd_fall = 0.0, t_rd_rise = -1.0e6, t_stby_rise = -1.0e6;
  int cv_falls = 0, rd_falls = 0, valid_cnt = 0;
  logic prev_valid = 1'b0;

  always @(negedge adc_convst_n) if (!rst) begin
    t_cv_fall = $realtime;
    cv_falls++;
    chk(t_cv_fall - t_rd_rise >= 300.0, "R5", "read-to-start ns",
        int'(t_cv_fall - t_rd_rise), 300);
    chk(t_cv_fall - t_stby_rise >= 2000.0, "R6", "wake-to-start ns",
        int'(t_cv_fall - t_stby_rise), 2000);
  end

  always @(posedge adc_convst_n) if (!rst)
    chk($realtime - t_cv_fall >= 35.0, "R2", "start low ns",
        int'($realtime - t_cv_fall), 35);

  always @(negedge adc_rd_n) if (!rst) begin
    t_rd_fall = $realtime;
    rd_falls++;
    chk(adc_busy == 1'b0, "R3", "busy at read", int'(adc_busy), 0);
    #1 chk(adc_cs_n == 1'b0, "R4", "cs with rd fall", int'(adc_cs_n), 0);
  end

  always @(posedge adc_rd_n) if (!rst) begin
    t_rd_rise = $realtime;
    chk($realtime - t_rd_fall >= 40.0, "R4", "read low ns",
        int'($realtime - t_rd_fall), 40);
    #1 chk(adc_cs_n == 1'b1, "R4", "cs with rd rise", int'(adc_cs_n), 1);
  end

  always @(posedge adc_stby_n) if (!rst) t_stby_rise = $realtime;

  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      valid_cnt++;
      chk(smp_data == word_ready, "R9", "sample word", int'(smp_data), int'(word_ready));
      chk(!prev_valid, "R9", "valid width", 2, 1);
    end
    prev_valid = smp_valid;
  end

  int exp_err = 0;

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_convst_n && adc_cs_n && adc_rd_n && adc_stby_n, "R1", "strobes high",
        int'({adc_convst_n, adc_cs_n, adc_rd_n, adc_stby_n}), 15);
    chk(smp_valid == 1'b0, "R1", "valid low", int'(smp_valid), 0);
    chk(err_count == '0, "R1", "errors zero", int'(err_count), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(cv_falls == 0, "R11", "no start while run low", cv_falls, 0);
  endtask

  task automatic t_normal(input int n);
    int v0, d0, c0, guard;
    mode = 0;
    v0 = valid_cnt;  d0 = conv_done;
    run = 1'b1;
    guard = 0;
    while (valid_cnt < v0 + n && guard < 20000) begin @(negedge clk); guard++; end
    run = 1'b0;
    repeat (600) @(negedge clk);
    chk(valid_cnt - v0 == n, "R9", "samples out", valid_cnt - v0, n);
    chk(conv_done - d0 == n, "R9", "conversions", conv_done - d0, n);
    c0 = cv_falls;
    repeat (200) @(negedge clk);
    chk(cv_falls == c0, "R11", "stays idle", cv_falls - c0, 0);
  endtask

  task automatic t_abort(input int m, input string req);
    int c0, v0, r0, guard;
    mode = m;
    c0 = cv_falls;  v0 = valid_cnt;  r0 = rd_falls;
    run = 1'b1;
    guard = 0;
    while (cv_falls == c0 && guard < 1000) begin @(negedge clk); guard++; end
    run = 1'b0;
    repeat (600) @(negedge clk);
    if (exp_err < 7) exp_err++;
    chk(int'(err_count) == exp_err, req, "error count", int'(err_count), exp_err);
    chk(valid_cnt == v0, req, "no sample", valid_cnt - v0, 0);
    chk(rd_falls == r0, req, "no read", rd_falls - r0, 0);
    mode = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_standby();
    int c0;
    sleep = 1'b1;
    run = 1'b1;
    c0 = cv_falls;
    repeat (50) @(negedge clk);
    chk(adc_stby_n == 1'b0, "R6", "standby asserted", int'(adc_stby_n), 0);
    chk(cv_falls == c0, "R6", "no start asleep", cv_falls - c0, 0);
    run = 1'b0;
    sleep = 1'b0;
    repeat (5) @(negedge clk);
    chk(adc_stby_n == 1'b1, "R6", "standby released", int'(adc_stby_n), 1);
    t_normal(1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 5; i++) t_abort(1, "R7");
    chk(int'(err_count) == 7, "R10", "reached max", int'(err_count), 7);
    t_abort(1, "R10");
    chk(int'(err_count) == 7, "R10", "held at max", int'(err_count), 7);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_normal(4);
    t_abort(1, "R7");
    t_abort(2, "R8");
    t_normal(2);
    t_standby();
    t_saturate();
    t_normal(1);
    finish_run();
  end
endmodule